// File: doc/BRIEF.md
# Reservation Station Pool with Result Snooping

This block holds operations that have been dispatched to a floating-point execution cluster but are still waiting. It has two banks: one feeds the adder unit, the other feeds the multiplier unit. A dispatched operation arrives with an opcode and, for each of its two sources, either a value or the tag of the station that will produce that value. The pool places the operation in a free station of the requested kind. The number of that station becomes the tag under which the operation's result will later be broadcast.

Each cycle, every source that is still waiting compares its tag with the tag on the shared result bus. On a match it takes the bus data. When both sources of a station hold values and the unit in front of that bank can accept work, the pool hands the operation to that unit. A station stays busy until its own result appears on the bus. This lets the tag name a single producer for the whole time consumers may still wait on it. Each bank reports whether it has a free station, so dispatch can hold the instruction back when it does not.

Top module: `rs_pool`

## Requirements
- R1: While reset is asserted, and right after it, every station is free. Both availability outputs are high, neither issue output is valid, and every stored tag is zero.
- R2: `disp_unit` = 0 selects the adder bank, whose three stations have tags 7, 8 and 9. `disp_unit` = 1 selects the multiplier bank, whose two stations have tags 10 and 11. A dispatch goes to the lowest-numbered free station of the selected bank. When that operation issues, its opcode and that station's tag appear on the bank's issue port.
- R3: A bank's availability output is low exactly when all of its stations are busy. A dispatch made to a bank while that output is low changes no station, and the operation never issues.
- R4: A source marked ready at dispatch (`*_rdy` = 1) is delivered at issue with the value given at dispatch.
- R5: A waiting source whose tag equals `bus_tag` while `bus_valid` is high takes `bus_data` at that clock edge and becomes ready. A broadcast with any other tag leaves it waiting.
- R6: A source dispatched not ready, in the same cycle that the bus broadcasts its tag, takes that cycle's bus data.
- R7: A bank's issue output is valid only while its `*_fu_ready` input is high and at least one station holds both sources ready and has not yet issued. A station issues once.
- R8: When several stations of one bank are ready together, the lowest-numbered one issues first.
- R9: A station that has issued becomes free at the clock edge where the bus broadcasts its tag. Issuing alone does not free it.
- R10: An operation dispatched with both sources ready in cycle k can issue in cycle k+1. A source captured at the edge ending cycle k can issue in cycle k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| disp_valid | input | 1 | A dispatched operation is offered this cycle |
| disp_unit | input | 1 | Target bank: 0 adder, 1 multiplier |
| disp_op | input | 3 | Opcode carried to the unit |
| disp_a_rdy | input | 1 | Source A holds a value |
| disp_a_tag | input | 4 | Producer tag of source A when not ready |
| disp_a_val | input | 32 | Value of source A when ready |
| disp_b_rdy | input | 1 | Source B holds a value |
| disp_b_tag | input | 4 | Producer tag of source B when not ready |
| disp_b_val | input | 32 | Value of source B when ready |
| bus_valid | input | 1 | The result bus carries a result this cycle |
| bus_tag | input | 4 | Tag of the result on the bus |
| bus_data | input | 32 | Result value on the bus |
| add_avail | output | 1 | The adder bank has a free station |
| mul_avail | output | 1 | The multiplier bank has a free station |
| add_fu_ready | input | 1 | The adder unit accepts an operation this cycle |
| add_iss_valid | output | 1 | An operation is handed to the adder unit |
| add_iss_op | output | 3 | Opcode of the issued adder operation |
| add_iss_a | output | 32 | Source A of the issued adder operation |
| add_iss_b | output | 32 | Source B of the issued adder operation |
| add_iss_tag | output | 4 | Result tag of the issued adder operation |
| mul_fu_ready | input | 1 | The multiplier unit accepts an operation this cycle |
| mul_iss_valid | output | 1 | An operation is handed to the multiplier unit |
| mul_iss_op | output | 3 | Opcode of the issued multiplier operation |
| mul_iss_a | output | 32 | Source A of the issued multiplier operation |
| mul_iss_b | output | 32 | Source B of the issued multiplier operation |
| mul_iss_tag | output | 4 | Result tag of the issued multiplier operation |

## Verification
A station that misses a broadcast never becomes ready, so its operation is absent from the issue port in the cycle after the capture should have made it ready. A station that takes data on a wrong tag shows a wrong operand value the first time it issues. A wrong busy or issued flag shows up as a stuck or early availability bit, or as a second issue of the same tag. This appears at the ports one cycle after the faulty edge. Because the bench compares every port in every cycle against a model of the stations, each of these faults is reported in the first cycle where it is visible.

// File: rtl/rs_pkg.sv
package rs_pkg;
    localparam int DATA_W = 32;
    localparam int TAG_W  = 4;
    localparam int OP_W   = 3;

    typedef struct packed {
        logic              rdy;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] val;
    } opnd_t;

    typedef struct packed {
        logic             busy;
        logic             issued;
        logic [OP_W-1:0]  op;
        opnd_t            a;
        opnd_t            b;
    } slot_t;

    typedef struct packed {
        logic              valid;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } bcast_t;

    // A waiting source takes the broadcast value when the tags agree.
    function automatic opnd_t snoop(opnd_t cur, bcast_t bc);
        opnd_t r;
        r = cur;
        if (!cur.rdy && bc.valid && (bc.tag == cur.tag)) begin
            r.rdy = 1'b1;
            r.tag = '0;
            r.val = bc.data;
        end
        return r;
    endfunction
endpackage

// File: rtl/rs_prio.sv
module rs_prio #(
    parameter int N = 3,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic [N-1:0]     gnt,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        gnt = '0;
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !any) begin
                gnt[i] = 1'b1;
                any    = 1'b1;
                idx    = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/rs_slot.sv
module rs_slot import rs_pkg::*; #(
    parameter int TAG = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  bcast_t          bc,
    input  logic            load,
    input  logic [OP_W-1:0] load_op,
    input  opnd_t           load_a,
    input  opnd_t           load_b,
    input  logic            take,
    output slot_t           st,
    output logic            ready
);
    slot_t slot_d, slot_q;
    logic  own_bcast;

    assign own_bcast = bc.valid && (bc.tag == TAG_W'(TAG));

    always_comb begin
        slot_d = slot_q;
        if (slot_q.busy) begin
            slot_d.a = snoop(slot_q.a, bc);
            slot_d.b = snoop(slot_q.b, bc);
            if (take) begin
                slot_d.issued = 1'b1;
            end
            if (slot_q.issued && own_bcast) begin
                slot_d = '0;
            end
        end else if (load) begin
            slot_d.busy   = 1'b1;
            slot_d.issued = 1'b0;
            slot_d.op     = load_op;
            slot_d.a      = snoop(load_a, bc);
            slot_d.b      = snoop(load_b, bc);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign st    = slot_q;
    assign ready = slot_q.busy && !slot_q.issued && slot_q.a.rdy && slot_q.b.rdy;
endmodule

// File: rtl/rs_bank.sv
module rs_bank import rs_pkg::*; #(
    parameter int N    = 3,
    parameter int BASE = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bcast_t            bc,
    input  logic              disp_en,
    input  logic [OP_W-1:0]   disp_op,
    input  opnd_t             disp_a,
    input  opnd_t             disp_b,
    input  logic              fu_ready,
    output logic              avail,
    output logic              iss_valid,
    output logic [OP_W-1:0]   iss_op,
    output logic [DATA_W-1:0] iss_a,
    output logic [DATA_W-1:0] iss_b,
    output logic [TAG_W-1:0]  iss_tag
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    slot_t            st [N];
    logic [N-1:0]     free_req, free_gnt;
    logic [N-1:0]     rdy_req, rdy_gnt;
    logic [N-1:0]     load, take;
    logic             rdy_any;
    logic [IDX_W-1:0] free_idx, rdy_idx;

    rs_prio #(.N(N)) u_free (
        .req (free_req),
        .gnt (free_gnt),
        .any (avail),
        .idx (free_idx)
    );

    rs_prio #(.N(N)) u_pick (
        .req (rdy_req),
        .gnt (rdy_gnt),
        .any (rdy_any),
        .idx (rdy_idx)
    );

    for (genvar i = 0; i < N; i++) begin : g_slot
        assign free_req[i] = !st[i].busy;
        assign load[i]     = disp_en && free_gnt[i];
        assign take[i]     = fu_ready && rdy_gnt[i];

        rs_slot #(.TAG(BASE + i)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .bc      (bc),
            .load    (load[i]),
            .load_op (disp_op),
            .load_a  (disp_a),
            .load_b  (disp_b),
            .take    (take[i]),
            .st      (st[i]),
            .ready   (rdy_req[i])
        );
    end

    logic unused_idx;
    assign unused_idx = ^free_idx;

    assign iss_valid = fu_ready && rdy_any;
    assign iss_op    = st[rdy_idx].op;
    assign iss_a     = st[rdy_idx].a.val;
    assign iss_b     = st[rdy_idx].b.val;
    assign iss_tag   = TAG_W'(BASE) + TAG_W'(rdy_idx);
endmodule

// File: rtl/rs_pool.sv
module rs_pool import rs_pkg::*; #(
    parameter int ADD_N    = 3,
    parameter int MUL_N    = 2,
    parameter int ADD_BASE = 7,
    parameter int MUL_BASE = ADD_BASE + ADD_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disp_valid,
    input  logic              disp_unit,
    input  logic [OP_W-1:0]   disp_op,
    input  logic              disp_a_rdy,
    input  logic [TAG_W-1:0]  disp_a_tag,
    input  logic [DATA_W-1:0] disp_a_val,
    input  logic              disp_b_rdy,
    input  logic [TAG_W-1:0]  disp_b_tag,
    input  logic [DATA_W-1:0] disp_b_val,
    input  logic              bus_valid,
    input  logic [TAG_W-1:0]  bus_tag,
    input  logic [DATA_W-1:0] bus_data,
    output logic              add_avail,
    output logic              mul_avail,
    input  logic              add_fu_ready,
    output logic              add_iss_valid,
    output logic [OP_W-1:0]   add_iss_op,
    output logic [DATA_W-1:0] add_iss_a,
    output logic [DATA_W-1:0] add_iss_b,
    output logic [TAG_W-1:0]  add_iss_tag,
    input  logic              mul_fu_ready,
    output logic              mul_iss_valid,
    output logic [OP_W-1:0]   mul_iss_op,
    output logic [DATA_W-1:0] mul_iss_a,
    output logic [DATA_W-1:0] mul_iss_b,
    output logic [TAG_W-1:0]  mul_iss_tag
);
    bcast_t bc;
    opnd_t  src_a, src_b;

    assign bc    = '{valid: bus_valid, tag: bus_tag, data: bus_data};
    assign src_a = '{rdy: disp_a_rdy, tag: disp_a_tag, val: disp_a_val};
    assign src_b = '{rdy: disp_b_rdy, tag: disp_b_tag, val: disp_b_val};

    rs_bank #(.N(ADD_N), .BASE(ADD_BASE)) u_add (
        .clk       (clk),
        .rst_n     (rst_n),
        .bc        (bc),
        .disp_en   (disp_valid && !disp_unit),
        .disp_op   (disp_op),
        .disp_a    (src_a),
        .disp_b    (src_b),
        .fu_ready  (add_fu_ready),
        .avail     (add_avail),
        .iss_valid (add_iss_valid),
        .iss_op    (add_iss_op),
        .iss_a     (add_iss_a),
        .iss_b     (add_iss_b),
        .iss_tag   (add_iss_tag)
    );

    rs_bank #(.N(MUL_N), .BASE(MUL_BASE)) u_mul (
        .clk       (clk),
        .rst_n     (rst_n),
        .bc        (bc),
        .disp_en   (disp_valid && disp_unit),
        .disp_op   (disp_op),
        .disp_a    (src_a),
        .disp_b    (src_b),
        .fu_ready  (mul_fu_ready),
        .avail     (mul_avail),
        .iss_valid (mul_iss_valid),
        .iss_op    (mul_iss_op),
        .iss_a     (mul_iss_a),
        .iss_b     (mul_iss_b),
        .iss_tag   (mul_iss_tag)
    );
endmodule

// File: rtl/rs_pool_chk.sv
module rs_pool_chk import rs_pkg::*; #(
    parameter int ADD_N    = 3,
    parameter int MUL_N    = 2,
    parameter int ADD_BASE = 7,
    parameter int MUL_BASE = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_valid,
    input logic [TAG_W-1:0] bus_tag,
    input logic             add_avail,
    input logic             mul_avail,
    input logic             add_iss_valid,
    input logic [TAG_W-1:0] add_iss_tag,
    input logic             mul_iss_valid,
    input logic [TAG_W-1:0] mul_iss_tag
);
    localparam int NTAG = 2 ** TAG_W;

    // Tags handed to a unit whose result has not yet been broadcast.
    logic [NTAG-1:0] out_d, out_q;

    always_comb begin
        out_d = out_q;
        if (bus_valid) out_d[bus_tag] = 1'b0;
        if (add_iss_valid) out_d[add_iss_tag] = 1'b1;
        if (mul_iss_valid) out_d[mul_iss_tag] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    p_reset_free_r1: assert property (@(posedge clk)
        !rst_n |-> (add_avail && mul_avail && !add_iss_valid && !mul_iss_valid));

    p_add_tag_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        add_iss_valid |-> (add_iss_tag >= TAG_W'(ADD_BASE)) &&
                          (add_iss_tag <  TAG_W'(ADD_BASE + ADD_N)));

    p_mul_tag_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mul_iss_valid |-> (mul_iss_tag >= TAG_W'(MUL_BASE)) &&
                          (mul_iss_tag <  TAG_W'(MUL_BASE + MUL_N)));

    p_add_single_issue_r7: assert property (@(posedge clk) disable iff (!rst_n)
        add_iss_valid |-> !out_q[add_iss_tag]);

    p_mul_single_issue_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mul_iss_valid |-> !out_q[mul_iss_tag]);

    p_add_free_on_bcast_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && out_q[bus_tag] && (bus_tag >= TAG_W'(ADD_BASE)) &&
         (bus_tag < TAG_W'(ADD_BASE + ADD_N))) |=> add_avail);

    p_mul_free_on_bcast_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && out_q[bus_tag] && (bus_tag >= TAG_W'(MUL_BASE)) &&
         (bus_tag < TAG_W'(MUL_BASE + MUL_N))) |=> mul_avail);
endmodule

bind rs_pool rs_pool_chk #(
    .ADD_N    (ADD_N),
    .MUL_N    (MUL_N),
    .ADD_BASE (ADD_BASE),
    .MUL_BASE (MUL_BASE)
) u_chk (.*);

// File: tb/sim_rs_pool.sv
`timescale 1ns/1ps
module sim_rs_pool;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        disp_valid = 1'b0, disp_unit = 1'b0;
    logic [2:0]  disp_op = '0;
    logic        disp_a_rdy = 1'b0, disp_b_rdy = 1'b0;
    logic [3:0]  disp_a_tag = '0, disp_b_tag = '0;
    logic [31:0] disp_a_val = '0, disp_b_val = '0;
    logic        bus_valid = 1'b0;
    logic [3:0]  bus_tag = '0;
    logic [31:0] bus_data = '0;
    logic        add_avail, mul_avail;
    logic        add_fu_ready = 1'b0, mul_fu_ready = 1'b0;
    logic        add_iss_valid, mul_iss_valid;
    logic [2:0]  add_iss_op, mul_iss_op;
    logic [31:0] add_iss_a, add_iss_b, mul_iss_a, mul_iss_b;
    logic [3:0]  add_iss_tag, mul_iss_tag;

    rs_pool u0 (.*);

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Model: stations 0..2 are adders (tags 7..9), 3..4 multipliers (10..11).
    bit          m_busy [5];
    bit          m_iss  [5];
    logic [2:0]  m_op   [5];
    bit          m_ar   [5], m_br [5];
    logic [3:0]  m_at   [5], m_bt [5];
    logic [31:0] m_av   [5], m_bv [5];

    function automatic int first_ready(int lo, int hi);
        for (int i = lo; i <= hi; i++)
            if (m_busy[i] && !m_iss[i] && m_ar[i] && m_br[i]) return i;
        return -1;
    endfunction

    function automatic int first_free(int lo, int hi);
        for (int i = lo; i <= hi; i++)
            if (!m_busy[i]) return i;
        return -1;
    endfunction

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic compare_bank(bit is_mul);
        int lo, hi, r;
        bit ev;
        lo = is_mul ? 3 : 0;
        hi = is_mul ? 4 : 2;
        r  = first_ready(lo, hi);
        if (!is_mul) begin
            ev = add_fu_ready && (r >= 0);
            chk("R3", "add avail", 64'(add_avail), 64'(first_free(lo, hi) >= 0));
            chk("R7", "add issue valid", 64'(add_iss_valid), 64'(ev));
            if (ev) begin
                chk("R8", "add issue tag", 64'(add_iss_tag), 64'(7 + r));
                chk("R2", "add issue op", 64'(add_iss_op), 64'(m_op[r]));
                chk("R4 R5 R6", "add operand a", 64'(add_iss_a), 64'(m_av[r]));
                chk("R4 R5 R6", "add operand b", 64'(add_iss_b), 64'(m_bv[r]));
            end
        end else begin
            ev = mul_fu_ready && (r >= 0);
            chk("R3", "mul avail", 64'(mul_avail), 64'(first_free(lo, hi) >= 0));
            chk("R7", "mul issue valid", 64'(mul_iss_valid), 64'(ev));
            if (ev) begin
                chk("R8", "mul issue tag", 64'(mul_iss_tag), 64'(7 + r));
                chk("R2", "mul issue op", 64'(mul_iss_op), 64'(m_op[r]));
                chk("R4 R5 R6", "mul operand a", 64'(mul_iss_a), 64'(m_av[r]));
                chk("R4 R5 R6", "mul operand b", 64'(mul_iss_b), 64'(m_bv[r]));
            end
        end
    endtask

    task automatic model_step();
        int ra, rm, lt;
        bit old_iss;
        ra = add_fu_ready ? first_ready(0, 2) : -1;
        rm = mul_fu_ready ? first_ready(3, 4) : -1;
        lt = -1;
        if (disp_valid) lt = disp_unit ? first_free(3, 4) : first_free(0, 2);
        for (int i = 0; i < 5; i++) begin
            if (m_busy[i]) begin
                old_iss = m_iss[i];
                if (!m_ar[i] && bus_valid && bus_tag == m_at[i]) begin m_ar[i] = 1; m_av[i] = bus_data; end
                if (!m_br[i] && bus_valid && bus_tag == m_bt[i]) begin m_br[i] = 1; m_bv[i] = bus_data; end
                if (i == ra || i == rm) m_iss[i] = 1;
                if (old_iss && bus_valid && bus_tag == 4'(7 + i)) begin
                    m_busy[i] = 0; m_iss[i] = 0; m_ar[i] = 0; m_br[i] = 0;
                end
            end else if (i == lt) begin
                m_busy[i] = 1; m_iss[i] = 0; m_op[i] = disp_op;
                m_ar[i] = disp_a_rdy; m_at[i] = disp_a_tag; m_av[i] = disp_a_val;
                m_br[i] = disp_b_rdy; m_bt[i] = disp_b_tag; m_bv[i] = disp_b_val;
                if (!m_ar[i] && bus_valid && bus_tag == m_at[i]) begin m_ar[i] = 1; m_av[i] = bus_data; end
                if (!m_br[i] && bus_valid && bus_tag == m_bt[i]) begin m_br[i] = 1; m_bv[i] = bus_data; end
            end
        end
    endtask

    // Inputs are set at a falling edge; outputs are compared 2 ns later.
    task automatic tick();
        #2;
        compare_bank(1'b0);
        compare_bank(1'b1);
        model_step();
        @(negedge clk);
    endtask

    task automatic dispatch(bit unit, logic [2:0] op, bit ar, logic [3:0] at, logic [31:0] av,
                            bit br, logic [3:0] bt, logic [31:0] bv);
        disp_valid = 1; disp_unit = unit; disp_op = op;
        disp_a_rdy = ar; disp_a_tag = at; disp_a_val = av;
        disp_b_rdy = br; disp_b_tag = bt; disp_b_val = bv;
    endtask

    task automatic random_cycle();
        int pick;
        int outs [$];
        disp_valid = ($urandom % 2) == 0;
        disp_unit  = $urandom % 2;
        disp_op    = 3'($urandom);
        disp_a_rdy = ($urandom % 3) != 0;
        disp_a_tag = 4'(1 + $urandom % 11);
        disp_a_val = $urandom;
        disp_b_rdy = ($urandom % 3) != 0;
        disp_b_tag = 4'(1 + $urandom % 11);
        disp_b_val = $urandom;
        add_fu_ready = ($urandom % 4) != 0;
        mul_fu_ready = ($urandom % 4) != 0;
        bus_valid  = ($urandom % 5) < 3;
        bus_data   = $urandom;
        for (int i = 0; i < 5; i++) if (m_busy[i] && m_iss[i]) outs.push_back(7 + i);
        pick = $urandom % 3;
        if (pick != 0 && outs.size() > 0) bus_tag = 4'(outs[$urandom % outs.size()]);
        else                              bus_tag = 4'(1 + $urandom % 11);
        tick();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 5; i++) begin
            m_busy[i] = 0; m_iss[i] = 0; m_op[i] = '0; m_ar[i] = 0; m_br[i] = 0;
            m_at[i] = '0; m_bt[i] = '0; m_av[i] = '0; m_bv[i] = '0;
        end
        add_fu_ready = 1; mul_fu_ready = 1;
        repeat (2) @(negedge clk);
        chk("R1", "add avail in reset", 64'(add_avail), 64'd1);
        chk("R1", "mul avail in reset", 64'(mul_avail), 64'd1);
        chk("R1", "add issue in reset", 64'(add_iss_valid), 64'd0);
        chk("R1", "mul issue in reset", 64'(mul_iss_valid), 64'd0);
        rst_n = 1'b1;
        add_fu_ready = 0; mul_fu_ready = 0;
        @(negedge clk);

        // R10: ready operands dispatched in cycle k issue in cycle k+1 from tag 7.
        dispatch(0, 3'd1, 1, 4'd0, 32'h5, 1, 4'd0, 32'h6);
        tick();
        disp_valid = 0; add_fu_ready = 1;
        #2;
        chk("R10", "first add issues next cycle", 64'(add_iss_valid), 64'd1);
        chk("R10", "first add tag", 64'(add_iss_tag), 64'd7);
        tick();

        // R3: fill the adder bank, then an extra dispatch is ignored.
        add_fu_ready = 0;
        dispatch(0, 3'd2, 0, 4'd3, 32'h0, 1, 4'd0, 32'h22);
        tick();
        dispatch(0, 3'd3, 0, 4'd3, 32'h0, 1, 4'd0, 32'h23);
        tick();
        dispatch(0, 3'd5, 1, 4'd0, 32'hDEAD, 1, 4'd0, 32'hBEEF);
        #2;
        chk("R3", "adder bank full", 64'(add_avail), 64'd0);
        tick();
        disp_valid = 0;
        bus_valid = 1; bus_tag = 4'd7; bus_data = 32'h77;
        tick();
        bus_valid = 0;
        #2;
        chk("R9", "broadcast frees station 7", 64'(add_avail), 64'd1);
        tick();
        // R5 and R8: both waiting adders capture tag 3, then issue in order.
        bus_valid = 1; bus_tag = 4'd3; bus_data = 32'h33;
        tick();
        bus_valid = 0; add_fu_ready = 1;
        #2;
        chk("R8", "lower station first", 64'(add_iss_tag), 64'd8);
        chk("R5", "captured value", 64'(add_iss_a), 64'h33);
        tick();
        tick();
        add_fu_ready = 0;
        tick();

        // R6: dispatch-cycle capture from the bus.
        bus_valid = 1; bus_tag = 4'd2; bus_data = 32'hABCD;
        dispatch(1, 3'd4, 0, 4'd2, 32'h0, 1, 4'd0, 32'h9);
        tick();
        bus_valid = 0; disp_valid = 0; mul_fu_ready = 1;
        #2;
        chk("R6", "bypass issue valid", 64'(mul_iss_valid), 64'd1);
        chk("R6", "bypass operand", 64'(mul_iss_a), 64'hABCD);
        tick();

        for (int n = 0; n < 4000; n++) random_cycle();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule